// File: doc/BRIEF.md
# Constant-Time Binary Modular Inverter

This block computes the multiplicative inverse of an operand `a` modulo an odd modulus `q`. It works in two phases. The first phase runs binary almost-inverse steps and leaves a value `s` equal to `a^-1 * 2^k mod q`. The second phase strips the factor `2^k` by halving `s` modulo `q`, once for each unit of `k`.

Each phase always takes exactly `2*W` clock cycles, whatever the operand value. Every step computes all of its candidate next values in parallel and picks one with multiplexers. When the work of a phase finishes early, the state stays frozen until that phase's cycle budget is spent. The run time therefore reveals nothing about the operand.

The operands are captured on `start` while the block is idle. After `4*W` iteration cycles, `done` pulses and `result` holds the inverse. Internal working registers are one 32-bit word wider than the operand, so intermediate growth never overflows.

Top module: `modinv_ct`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy` and `done` are both 0.
- R2: A `start` pulse sampled while `busy` is 0 captures `a_in` and `q_in`, and `busy` reads 1 in the following cycle.
- R3: `done` is first seen high in the cycle after the `4*W`-th clock edge that follows the edge sampling `start`. This holds for every operand value. The internal power-of-two counter never exceeds `2*W`.
- R4: `done` is a one-cycle pulse, and `busy` is 0 whenever `done` is 1.
- R5: For an odd `q` below `2^W` and an `a` in `[1, q)` coprime to `q`, `result` satisfies `a*result mod q = 1` and `result < q` when `done` is high.
- R6: While `busy` is 1, further `start` pulses and any changes on `a_in` or `q_in` have no effect on the result being computed.
- R7: An operand of 1 yields 1, and an operand of `q-1` yields `q-1`.
- R8: While idle with `start` low, `result` holds its last value, regardless of `a_in` and `q_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion; sampled only while idle |
| a_in | input | W | Operand to invert |
| q_in | input | W | Odd modulus |
| busy | output | 1 | High while an inversion is in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | W | Inverse of the captured operand modulo the captured modulus |

## Verification
The assertions assume that `q` is odd, that `a` is nonzero and coprime to `q`, and that both are below `2^W`. Only under these conditions does phase 1 reach `v = 1` within its budget, which bounds the exponent counter and keeps the result below `q`. The stimulus uses two fixed primes as moduli and reduces each random operand modulo the prime, replacing zero with one. Every operand is therefore a valid unit, and no input outside the assumed range is ever driven.

// File: rtl/modinv_ct.sv
module modinv_ct #(
  parameter int W    = 64,
  parameter int WORD = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] q_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int XW   = W + WORD;
  localparam int IT   = 2 * W;
  localparam int CNTW = $clog2(2 * IT);
  localparam int KW   = $clog2(IT) + 1;
  localparam int NWD  = (XW + WORD - 1) / WORD;
  localparam int PW   = NWD * WORD;

  logic [XW-1:0]   u, v, r, s, qx;
  logic [KW-1:0]   k;
  logic [CNTW-1:0] cnt;

  // word-serial magnitude compare, top word first, every word visited
  function automatic logic above(input logic [XW-1:0] x, input logic [XW-1:0] y);
    logic [PW-1:0] xp, yp;
    logic decided, res;
    xp = PW'(x);
    yp = PW'(y);
    decided = 1'b0;
    res = 1'b0;
    for (int i = NWD - 1; i >= 0; i--) begin
      if (!decided && (xp[i*WORD +: WORD] != yp[i*WORD +: WORD])) begin
        decided = 1'b1;
        res = xp[i*WORD +: WORD] > yp[i*WORD +: WORD];
      end
    end
    return res;
  endfunction

  wire          ph2    = (cnt >= CNTW'(IT));
  wire          last   = (cnt == CNTW'(2 * IT - 1));
  wire          u_even = ~u[0];
  wire          v_even = ~v[0];
  wire          v_one  = (v == XW'(1));
  wire          u_gt   = above(u, v);
  wire [XW-1:0] u_m_v  = u - v;
  wire [XW-1:0] v_m_u  = v - u;
  wire [XW-1:0] r_p_s  = r + s;
  wire [XW-1:0] s_p_q  = s + qx;
  wire [XW-1:0] s_fix  = s[0] ? (s_p_q >> 1) : (s >> 1);

  logic [XW-1:0] un, vn, rn, sn;

  always_comb begin
    un = u;
    vn = v;
    rn = r;
    sn = s;
    if (u_even) begin
      un = u >> 1;
      sn = s << 1;
    end else if (v_even) begin
      vn = v >> 1;
      rn = r << 1;
    end else if (u_gt) begin
      un = u_m_v >> 1;
      rn = r_p_s;
      sn = s << 1;
    end else begin
      vn = v_m_u >> 1;
      rn = r << 1;
      sn = r_p_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u    <= '0;
      v    <= '0;
      r    <= '0;
      s    <= '0;
      qx   <= '0;
      k    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          u    <= XW'(q_in);
          qx   <= XW'(q_in);
          v    <= XW'(a_in);
          r    <= '0;
          s    <= XW'(1);
          k    <= '0;
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else begin
        if (!ph2) begin
          if (!v_one) begin
            u <= un;
            v <= vn;
            r <= rn;
            s <= sn;
            k <= k + KW'(1);
          end
        end else if (k != '0) begin
          s <= s_fix;
          k <= k - KW'(1);
        end
        cnt <= cnt + CNTW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign result = s[W-1:0];

  p_k_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (k <= KW'(IT)));
  p_k_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (k == '0));
  p_result_below_q_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (s < qx));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  p_modulus_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(qx));
endmodule

// File: tb/sim_modinv_ct.sv
`timescale 1ns/1ps
module sim_modinv_ct;
  localparam int W = 64;
  localparam int LAT = 4 * W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] q_in = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  modinv_ct #(.W(W), .WORD(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .q_in(q_in),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] powmod(input logic [63:0] b, input logic [63:0] e, input logic [63:0] m);
    logic [127:0] acc, base;
    acc = 128'd1;
    base = {64'd0, b} % {64'd0, m};
    for (int i = 0; i < 64; i++) begin
      if (e[i]) acc = (acc * base) % {64'd0, m};
      base = (base * base) % {64'd0, m};
    end
    return acc[63:0];
  endfunction

  function automatic logic [63:0] mulmod(input logic [63:0] x, input logic [63:0] y, input logic [63:0] m);
    logic [127:0] p;
    p = ({64'd0, x} * {64'd0, y}) % {64'd0, m};
    return p[63:0];
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] q, input bit disturb,
                     output logic [63:0] res, output int lat);
    @(negedge clk);
    a_in = a;
    q_in = q;
    start = 1'b1;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (lat == 1) begin
        chk(busy === 1'b1, "R2 busy after start", {127'd0, busy}, 128'd1);
        if (disturb) begin
          a_in = a ^ 64'h5A5A_0000_1234_0001;
          q_in = q ^ 64'h0000_0000_0000_0006;
        end
      end
      if (disturb && lat == 20) start = 1'b1;
    end while (!done && lat < 5000);
    start = 1'b0;
    res = result;
    chk(lat == LAT, "R3 latency", 128'(lat), 128'(LAT));
    chk(busy === 1'b0, "R4 busy low with done", {127'd0, busy}, 128'd0);
    @(negedge clk);
    chk(done === 1'b0, "R4 done single cycle", {127'd0, done}, 128'd0);
  endtask

  task automatic inv_case(input logic [63:0] a, input logic [63:0] q, input bit disturb, input string req);
    logic [63:0] res, exp;
    int lat;
    run(a, q, disturb, res, lat);
    exp = powmod(a, q - 64'd2, q);
    chk(res == exp, req, {64'd0, res}, {64'd0, exp});
    chk(mulmod(a, res, q) == 64'd1, "R5 product is one", {64'd0, mulmod(a, res, q)}, 128'd1);
    chk(res < q, "R5 below modulus", {64'd0, res}, {64'd0, q});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] q1, q2, a, held;
    logic [63:0] res;
    int lat;
    void'($urandom(32'd2718));
    q1 = 64'hFFFF_FFFF_FFFF_FFC5;
    q2 = 64'h1FFF_FFFF_FFFF_FFFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset state", {126'd0, busy, done}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 after reset", {126'd0, busy, done}, 128'd0);

    run(64'd1, q1, 1'b0, res, lat);
    chk(res == 64'd1, "R7 inverse of one", {64'd0, res}, 128'd1);
    run(q1 - 64'd1, q1, 1'b0, res, lat);
    chk(res == q1 - 64'd1, "R7 inverse of q-1", {64'd0, res}, {64'd0, q1 - 64'd1});
    run(q2 - 64'd1, q2, 1'b0, res, lat);
    chk(res == q2 - 64'd1, "R7 inverse of q-1 small", {64'd0, res}, {64'd0, q2 - 64'd1});
    inv_case(64'd2, q1, 1'b0, "R5 inverse of two");
    inv_case(64'h8000_0000_0000_0000, q1, 1'b0, "R5 power of two");
    inv_case(q1 - 64'd2, q1, 1'b0, "R5 q-2");

    for (int i = 0; i < 20; i++) begin
      a = {$urandom, $urandom} % q1;
      if (a == 64'd0) a = 64'd1;
      inv_case(a, q1, 1'b0, "R5 random large prime");
    end
    for (int i = 0; i < 10; i++) begin
      a = {$urandom, $urandom} % q2;
      if (a == 64'd0) a = 64'd1;
      inv_case(a, q2, 1'b0, "R5 random small prime");
    end

    inv_case(64'h0123_4567_89AB_CDEF, q1, 1'b1, "R6 busy ignores inputs");
    inv_case(64'h0000_0000_0000_0003, q2, 1'b1, "R6 busy ignores restart");

    held = result;
    @(negedge clk);
    a_in = 64'h7777_0000_7777_0000;
    q_in = 64'd11;
    repeat (4) @(negedge clk);
    chk(result == held, "R8 result holds while idle", {64'd0, result}, {64'd0, held});
    chk(busy === 1'b0, "R8 stays idle without start", {127'd0, busy}, 128'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule